// File: doc/BRIEF.md
# Ethernet transmit pad and CRC framer

This block sits in a MAC transmit path between the frame buffer and the serializer. For every frame the host first presents a command that carries the declared byte length and two mode bits, `cmd_no_crc` and `cmd_no_pad`. The frame's bytes then follow on a valid/ready input stream. The block forwards those bytes unchanged. Depending on the mode, it then adds zero bytes up to the minimum data size and appends the 32-bit frame check sequence. The result goes out on a valid/ready stream with an end marker on its final byte.

A frame declared shorter than three bytes is refused. The block raises a one-cycle reject flag, sends nothing and takes no data bytes. When the input stream ends early, the block marks an underrun: it closes the output frame on the last byte it received and adds neither pad nor check sequence. Every emitted frame is followed by a one-cycle done pulse that reports how many bytes went out.

Top module: `eth_tx_framer`

## Requirements
- R1: With both mode bits clear, data shorter than 60 bytes is followed by zero bytes up to 60 and then by the 4-byte check sequence, so the frame is at least 64 bytes. Longer data gets no pad.
- R2: With `cmd_no_crc`=1 and `cmd_no_pad`=0, short data is padded with zeros to 60 bytes and no check sequence follows.
- R3: With `cmd_no_crc`=0 and `cmd_no_pad`=1, the data is sent at its declared length, even below 60, followed by the check sequence. The total is length+4.
- R4: With both mode bits set, exactly the declared number of bytes is sent. There is no pad and no check sequence.
- R5: A command whose length is below 3 is refused. `reject` is high for exactly the one cycle after the command handshake. The block consumes no input byte and emits no output byte for it.
- R6: The check sequence is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, result inverted). It covers all data and pad bytes and is sent least significant byte first. For the ASCII data "123456789" the check bytes are 26 39 F4 CB.
- R7: Every pad byte has the value 0x00.
- R8: `out_last` is high on the final byte of each frame and only there. `done_valid` is high for exactly the cycle after that byte's handshake, and `done_count` then holds the number of bytes in the frame.
- R9: If `in_last` arrives on a byte before the declared length is reached, that byte is emitted with `out_last`. No pad or check bytes follow, and the done pulse carries `done_underrun`=1 with the count of bytes sent.
- R10: `cmd_ready` is high only while no frame is in progress. The length and mode are captured at the command handshake and apply to that frame alone.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged in the next cycle, given a source that holds its own stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Frame command present |
| cmd_ready | output | 1 | Command accepted (idle) |
| cmd_len | input | LEN_W | Declared data length in bytes |
| cmd_no_crc | input | 1 | Suppress the check sequence |
| cmd_no_pad | input | 1 | Suppress zero padding |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Source's final byte of the frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the output frame |
| done_valid | output | 1 | One-cycle frame completion pulse |
| done_count | output | LEN_W+1 | Bytes emitted in the completed frame |
| done_underrun | output | 1 | Completed frame ended early |
| reject | output | 1 | One-cycle pulse for a refused command |

## Verification
The assertions run on every cycle. They check the reported total for each of the four modes against the captured length, the refusal pulse after a short command, and that the done pulse follows the closing byte. They also check that commands are held off while a frame is in progress, that an underrun count falls short of the declared length, and that output stays steady under backpressure. Only the bench's scenarios can show the actual byte contents: the forwarded data, the zero pad values, the CRC bytes and their order, and where the end marker falls. The same holds for the absence of input consumption on a refused command and for correct behaviour across sink stalls and back-to-back frames.

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int LEN_W    = 11,
  parameter int MIN_DATA = 60,
  parameter int FLOOR    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_no_crc,
  input  logic             cmd_no_pad,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             done_valid,
  output logic [LEN_W:0]   done_count,
  output logic             done_underrun,
  output logic             reject
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAD, S_FCS} st_t;

  st_t              st;
  logic [LEN_W-1:0] len_q, cnt;
  logic             no_crc_q, no_pad_q;
  logic [31:0]      crc_q;
  logic [1:0]       fcs_idx;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire [LEN_W-1:0] cnt_inc  = cnt + 1'b1;
  wire             data_end = (cnt_inc == len_q);
  wire             need_pad = !no_pad_q && (cnt_inc < LEN_W'(MIN_DATA));
  wire             pad_end  = (cnt_inc >= LEN_W'(MIN_DATA));
  wire             ur       = in_last && !data_end;
  wire             fire     = out_valid && out_ready;
  wire [31:0]      crc_nx   = crc_byte(crc_q, out_data);

  assign cmd_ready = (st == S_IDLE);
  assign in_ready  = (st == S_DATA) && out_ready;
  assign out_valid = (st == S_DATA) ? in_valid : (st == S_PAD || st == S_FCS);
  assign out_data  = (st == S_DATA) ? in_data : (st == S_FCS) ? ~crc_q[7:0] : 8'h00;

  always_comb begin
    case (st)
      S_DATA:  out_last = ur || (data_end && !need_pad && no_crc_q);
      S_PAD:   out_last = pad_end && no_crc_q;
      S_FCS:   out_last = (fcs_idx == 2'd3);
      default: out_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      len_q         <= '0;
      no_crc_q      <= 1'b0;
      no_pad_q      <= 1'b0;
      cnt           <= '0;
      crc_q         <= '1;
      fcs_idx       <= '0;
      done_valid    <= 1'b0;
      done_count    <= '0;
      done_underrun <= 1'b0;
      reject        <= 1'b0;
    end else begin
      done_valid    <= 1'b0;
      done_underrun <= 1'b0;
      reject        <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (cmd_len < LEN_W'(FLOOR)) reject <= 1'b1;
          else begin
            st       <= S_DATA;
            len_q    <= cmd_len;
            no_crc_q <= cmd_no_crc;
            no_pad_q <= cmd_no_pad;
            cnt      <= '0;
            crc_q    <= '1;
            fcs_idx  <= '0;
          end
        end
        S_DATA: if (fire) begin
          cnt   <= cnt_inc;
          crc_q <= crc_nx;
          if (ur || (data_end && !need_pad && no_crc_q)) begin
            st            <= S_IDLE;
            done_valid    <= 1'b1;
            done_count    <= {1'b0, cnt_inc};
            done_underrun <= ur;
          end else if (data_end) st <= need_pad ? S_PAD : S_FCS;
        end
        S_PAD: if (fire) begin
          cnt   <= cnt_inc;
          crc_q <= crc_nx;
          if (pad_end) begin
            if (no_crc_q) begin
              st         <= S_IDLE;
              done_valid <= 1'b1;
              done_count <= {1'b0, cnt_inc};
            end else st <= S_FCS;
          end
        end
        S_FCS: if (fire) begin
          crc_q   <= crc_q >> 8;
          fcs_idx <= fcs_idx + 1'b1;
          if (fcs_idx == 2'd3) begin
            st         <= S_IDLE;
            done_valid <= 1'b1;
            done_count <= {1'b0, cnt} + CNT_W'(4);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PAD_MIN_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_underrun && !no_pad_q && !no_crc_q |-> done_count >= CNT_W'(MIN_DATA + 4)); // R1
  AST_PAD_MIN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_underrun && !no_pad_q && no_crc_q |-> done_count >= CNT_W'(MIN_DATA)); // R2
  AST_RUNT_WITH_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_underrun && no_pad_q && !no_crc_q |-> done_count == {1'b0, len_q} + CNT_W'(4)); // R3
  AST_RUNT_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_underrun && no_pad_q && no_crc_q |-> done_count == {1'b0, len_q}); // R4
  AST_SHORT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_len < LEN_W'(FLOOR) |=> reject && !out_valid); // R5
  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done_valid); // R8
  AST_UNDERRUN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    done_underrun |-> done_valid && done_count < {1'b0, len_q}); // R9
  AST_CMD_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready); // R10
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
endmodule

// File: tb/eth_tx_framer_bench.sv
`timescale 1ns/1ps
module eth_tx_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_no_crc = 1'b0, cmd_no_pad = 1'b0;
  logic [10:0] cmd_len = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cmd_ready, in_ready, out_valid, out_last;
  logic [7:0]  out_data;
  logic        done_valid, done_underrun, reject;
  logic [11:0] done_count;

  always #2.5 clk = ~clk;

  eth_tx_framer u_eth_tx_framer (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
    .cmd_no_crc(cmd_no_crc), .cmd_no_pad(cmd_no_pad),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done_valid(done_valid), .done_count(done_count), .done_underrun(done_underrun),
    .reject(reject)
  );

  // columns: length, no_crc, no_pad, underrun position (0 = none), expected total
  localparam int NV = 12;
  localparam int VEC [NV][5] = '{
    '{10, 0, 0, 0, 64},  // R1 R7 padded
    '{59, 0, 0, 0, 64},  // R1 one pad byte
    '{60, 0, 0, 0, 64},  // R1 no pad needed
    '{70, 0, 0, 0, 74},  // R1 long
    '{10, 1, 0, 0, 60},  // R2
    '{60, 1, 0, 0, 60},  // R2 boundary
    '{10, 0, 1, 0, 14},  // R3 runt
    '{3,  1, 1, 0, 3},   // R4 floor
    '{63, 1, 1, 0, 63},  // R4 runt
    '{20, 0, 0, 7, 7},   // R9 underrun
    '{3,  0, 0, 0, 64},  // R1 floor padded
    '{40, 1, 1, 1, 1}    // R9 underrun on first byte
  };

  int nchk = 0, nfail = 0;
  bit ended = 0;
  logic [7:0] expb [0:2047];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'h0, expb[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] src_byte(input int seed, input int k, input bit ascii);
    return ascii ? 8'(8'h31 + k) : 8'(seed * 31 + k * 13 + 5);
  endfunction

  task automatic run_frame(input int len, input bit nc, input bit np, input int urpos,
                           input int exp_tot, input bit stall, input int seed, input bit ascii);
    int nsend, n, sent, got, cyc;
    bit fin, got_all;
    logic [31:0] crc;
    nsend = (urpos != 0) ? urpos : len;
    for (int k = 0; k < nsend; k++) expb[k] = src_byte(seed, k, ascii);
    n = nsend;
    if (urpos == 0) begin
      if (!np) while (n < 60) begin expb[n] = 8'h00; n++; end
      if (!nc) begin
        crc = ref_crc(n);
        for (int b = 0; b < 4; b++) begin expb[n] = crc[8*b +: 8]; n++; end
      end
    end
    check(n == exp_tot, "TBL", n, exp_tot);
    @(negedge clk);
    cmd_valid = 1; cmd_len = 11'(len); cmd_no_crc = nc; cmd_no_pad = np;
    #1 check(cmd_ready == 1, "R10", cmd_ready, 1);
    sent = 0; got = 0; cyc = 0; fin = 0; got_all = 0;
    while (!fin && cyc < 600) begin
      @(negedge clk);
      cmd_valid = 0;
      in_valid  = (sent < nsend);
      in_data   = (sent < nsend) ? expb[sent] : 8'h00;
      in_last   = (sent == nsend - 1);
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      #1;
      if (got_all) begin
        check(done_valid == 1, "R8", done_valid, 1);
        check(done_count == 12'(exp_tot), "R8", done_count, exp_tot);
        check(done_underrun == (urpos != 0), (urpos != 0) ? "R9" : "R8", done_underrun, urpos != 0);
        fin = 1;
      end else begin
        if (cyc == 0) check(cmd_ready == 0, "R10", cmd_ready, 0);
        if (in_valid && in_ready) sent++;
        if (out_valid && out_ready) begin
          check(out_data == expb[got], (got >= nsend && !np && got < 60) ? "R7" : "R6", out_data, expb[got]);
          check(out_last == (got == n - 1), "R8", out_last, got == n - 1);
          got++;
          if (got == n) got_all = 1;
        end
        if (done_valid && !got_all) check(0, "R8", 1, 0);
      end
      cyc++;
    end
    if (!fin) check(0, "R8", got, n);
    in_valid = 0; in_last = 0;
  endtask

  task automatic refuse(input int len);
    @(negedge clk);
    cmd_valid = 1; cmd_len = 11'(len); cmd_no_crc = 0; cmd_no_pad = 0;
    in_valid = 1; in_data = 8'hAA; in_last = 0; out_ready = 1;
    @(negedge clk);
    cmd_valid = 0;
    #1;
    check(reject == 1, "R5", reject, 1);
    check(out_valid == 0, "R5", out_valid, 0);
    check(in_ready == 0, "R5", in_ready, 0);
    @(negedge clk);
    #1;
    check(reject == 0, "R5", reject, 0);
    check(in_ready == 0 && out_valid == 0, "R5", {in_ready, out_valid}, 0);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(cmd_ready == 1, "R10", cmd_ready, 1);
    check(out_valid == 0, "R8", out_valid, 0);
    check(done_valid == 0 && reject == 0, "R5", {done_valid, reject}, 0);
    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][0], VEC[v][1] != 0, VEC[v][2] != 0, VEC[v][3], VEC[v][4], (v % 2) == 0, v + 1, 0);
    refuse(0);
    refuse(1);
    refuse(2);
    run_frame(9, 0, 1, 0, 13, 1, 0, 1);
    check({expb[9], expb[10], expb[11], expb[12]} == 32'h2639F4CB, "R6",
          {expb[9], expb[10], expb[11], expb[12]}, 32'h2639F4CB);
    run_frame(5, 1, 1, 0, 5, 0, 77, 0);  // R10 next frame uses its own mode
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule